// File: doc/BRIEF.md
# Stack Machine Execution Unit

This block is the data-path core of an 8-bit stack processor. Each cycle it may accept one instruction byte together with the three topmost stack items. It splits the byte into its mode flags and its five-bit operation code, then computes the items that must be written back to the stack. It also reports how many items the stack controller has to remove and how many it has to append. The unit covers increment, the stack shuffles (drop, nip, swap, rotate, duplicate, over), four comparisons, and the arithmetic and logic group from add through shift. Memory, device traffic, branching and the stack storage itself belong to neighbouring blocks.

Operands arrive as full 16-bit items. In byte mode only their low byte takes part, and every result is zero-extended. In short mode whole 16-bit items are used. The unit is pipelined with one register stage. The stack controller reads the returned item list in order: slot 0 is appended first (deepest) and slot 2 last (topmost). It uses the return flag, which is copied out, to choose which of its two stacks the operation works on.

Top module: `stk_exec_unit`

## Requirements
- R1: Instruction bit 7 is the keep flag, bit 6 the return flag, bit 5 the short flag and bits 4..0 the operation code. Every output is registered and appears one clock after an edge that sees in_valid=1. out_valid equals in_valid one cycle late. Synchronous reset clears every output to zero.
- R2: Removed/appended item counts are: INC 0x01 1/1, POP 0x02 1/0, NIP 0x03 2/1, SWP 0x04 2/2, ROT 0x05 3/3, DUP 0x06 1/2, OVR 0x07 2/3, comparisons 0x08..0x0B 2/1, ADD..SFT 0x18..0x1F 2/1. With the keep flag set, the removed count is 0 and the appended items are unchanged.
- R3: With T the top item, S the second and U the third, result slots (slot 0 deepest) are: NIP {T}, SWP {T,S}, ROT {S,T,U}, DUP {T,T}, OVR {S,T,S}. POP yields no items. Unused slots read 0.
- R4: INC gives T+1, ADD 0x18 gives S+T, SUB 0x19 gives S-T and MUL 0x1A gives S*T. Each wraps modulo 2^8 in byte mode and modulo 2^16 in short mode.
- R5: DIV 0x1B gives the unsigned quotient S/T, and gives 0 when T is 0.
- R6: AND 0x1C, ORA 0x1D and EOR 0x1E give the bitwise and, or and xor of S and T over the active width.
- R7: SFT 0x1F shifts S right by T[3:0], then left by T[7:4], and truncates the result to the active width.
- R8: EQU 0x08, NEQ 0x09, GTH 0x0A (S>T) and LTH 0x0B (S<T) return one item of value 0 or 1. out_wide is 0 for them, even in short mode.
- R9: In byte mode, operand bits 15..8 are ignored, every result slot has bits 15..8 at 0, and out_wide is 0. In short mode out_wide is 1 for all non-comparison supported codes.
- R10: out_swap_stacks repeats the return flag of the captured instruction.
- R11: Opcode 0x00 and 0x0C..0x17 are unsupported. For them out_unsupported is 1, both counts are 0, all result slots are 0 and out_wide is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present this cycle |
| in_instr | input | 8 | Instruction byte (flags and operation code) |
| opnd_top | input | 16 | Topmost stack item T |
| opnd_second | input | 16 | Second stack item S |
| opnd_third | input | 16 | Third stack item U |
| out_valid | output | 1 | Registered result is present |
| out_res0 | output | 16 | Result slot 0 (appended first) |
| out_res1 | output | 16 | Result slot 1 |
| out_res2 | output | 16 | Result slot 2 (appended last) |
| out_pop_cnt | output | 2 | Items to remove from the stack |
| out_push_cnt | output | 2 | Items to append to the stack |
| out_wide | output | 1 | Appended items are 16-bit |
| out_swap_stacks | output | 1 | Copy of the return flag |
| out_unsupported | output | 1 | Operation code not handled by this unit |

## Verification
Each result is due at the first rising edge after the instruction is presented, so out_valid and every slot and count change exactly one clock later. The bench changes inputs only on falling edges. It samples the outputs at the very next falling edge, so one rising edge lies between stimulus and check. It also checks an idle cycle to show that out_valid drops one cycle after in_valid does.

// File: rtl/stk_exec_pkg.sv
package stk_exec_pkg;

    typedef enum logic [4:0] {
        OP_BRK = 5'h00,
        OP_INC = 5'h01,
        OP_POP = 5'h02,
        OP_NIP = 5'h03,
        OP_SWP = 5'h04,
        OP_ROT = 5'h05,
        OP_DUP = 5'h06,
        OP_OVR = 5'h07,
        OP_EQU = 5'h08,
        OP_NEQ = 5'h09,
        OP_GTH = 5'h0A,
        OP_LTH = 5'h0B,
        OP_ADD = 5'h18,
        OP_SUB = 5'h19,
        OP_MUL = 5'h1A,
        OP_DIV = 5'h1B,
        OP_AND = 5'h1C,
        OP_ORA = 5'h1D,
        OP_EOR = 5'h1E,
        OP_SFT = 5'h1F
    } op_e;

    typedef struct packed {
        logic       keep;
        logic       ret;
        logic       wide;
        op_e        op;
        logic       known;
        logic       is_cmp;
        logic       is_shuf;
        logic [1:0] n_in;
        logic [1:0] n_out;
    } dec_t;

    function automatic dec_t decode_instr(input logic [7:0] ins);
        dec_t d;
        d.keep    = ins[7];
        d.ret     = ins[6];
        d.wide    = ins[5];
        d.op      = op_e'(ins[4:0]);
        d.known   = 1'b1;
        d.is_cmp  = 1'b0;
        d.is_shuf = 1'b0;
        d.n_in    = 2'd2;
        d.n_out   = 2'd1;
        case (ins[4:0])
            5'h01: d.n_in = 2'd1;
            5'h02: begin d.n_in = 2'd1; d.n_out = 2'd0; d.is_shuf = 1'b1; end
            5'h03: d.is_shuf = 1'b1;
            5'h04: begin d.n_out = 2'd2; d.is_shuf = 1'b1; end
            5'h05: begin d.n_in = 2'd3; d.n_out = 2'd3; d.is_shuf = 1'b1; end
            5'h06: begin d.n_in = 2'd1; d.n_out = 2'd2; d.is_shuf = 1'b1; end
            5'h07: begin d.n_out = 2'd3; d.is_shuf = 1'b1; end
            5'h08, 5'h09, 5'h0A, 5'h0B: d.is_cmp = 1'b1;
            5'h18, 5'h19, 5'h1A, 5'h1B,
            5'h1C, 5'h1D, 5'h1E, 5'h1F: d.n_in = 2'd2;
            default: begin
                d.known = 1'b0;
                d.n_in  = 2'd0;
                d.n_out = 2'd0;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/stk_decode.sv
module stk_decode
    import stk_exec_pkg::*;
(
    input  logic [7:0] ins,
    output dec_t       dec
);
    assign dec = decode_instr(ins);
endmodule

// File: rtl/stk_arith.sv
module stk_arith
    import stk_exec_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 2 * BYTE_W
) (
    input  op_e               op,
    input  logic              wide,
    input  logic [WORD_W-1:0] t_in,
    input  logic [WORD_W-1:0] s_in,
    output logic [WORD_W-1:0] res
);
    localparam int NIB = BYTE_W / 2;
    localparam logic [WORD_W-1:0] LOW_MASK = {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

    logic [WORD_W-1:0] full;

    always_comb begin
        case (op)
            OP_INC:  full = t_in + WORD_W'(1);
            OP_EQU:  full = WORD_W'(s_in == t_in);
            OP_NEQ:  full = WORD_W'(s_in != t_in);
            OP_GTH:  full = WORD_W'(s_in > t_in);
            OP_LTH:  full = WORD_W'(s_in < t_in);
            OP_ADD:  full = s_in + t_in;
            OP_SUB:  full = s_in - t_in;
            OP_MUL:  full = s_in * t_in;
            OP_DIV:  full = (t_in == '0) ? '0 : s_in / t_in;
            OP_AND:  full = s_in & t_in;
            OP_ORA:  full = s_in | t_in;
            OP_EOR:  full = s_in ^ t_in;
            OP_SFT:  full = (s_in >> t_in[NIB-1:0]) << t_in[BYTE_W-1:NIB];
            default: full = '0;
        endcase
        res = wide ? full : (full & LOW_MASK);
    end
endmodule

// File: rtl/stk_permute.sv
module stk_permute
    import stk_exec_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  op_e               op,
    input  logic [WORD_W-1:0] t_in,
    input  logic [WORD_W-1:0] s_in,
    input  logic [WORD_W-1:0] u_in,
    output logic [WORD_W-1:0] slot0,
    output logic [WORD_W-1:0] slot1,
    output logic [WORD_W-1:0] slot2
);
    always_comb begin
        slot0 = '0;
        slot1 = '0;
        slot2 = '0;
        case (op)
            OP_NIP: slot0 = t_in;
            OP_SWP: begin slot0 = t_in; slot1 = s_in; end
            OP_ROT: begin slot0 = s_in; slot1 = t_in; slot2 = u_in; end
            OP_DUP: begin slot0 = t_in; slot1 = t_in; end
            OP_OVR: begin slot0 = s_in; slot1 = t_in; slot2 = s_in; end
            default: ;
        endcase
    end
endmodule

// File: rtl/stk_exec_unit.sv
module stk_exec_unit
    import stk_exec_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 2 * BYTE_W,
    parameter int N_OPND = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_instr,
    input  logic [WORD_W-1:0] opnd_top,
    input  logic [WORD_W-1:0] opnd_second,
    input  logic [WORD_W-1:0] opnd_third,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_res0,
    output logic [WORD_W-1:0] out_res1,
    output logic [WORD_W-1:0] out_res2,
    output logic [1:0]        out_pop_cnt,
    output logic [1:0]        out_push_cnt,
    output logic              out_wide,
    output logic              out_swap_stacks,
    output logic              out_unsupported
);
    localparam logic [WORD_W-1:0] LOW_MASK = {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};

    dec_t dec;
    logic [WORD_W-1:0] raw   [N_OPND];
    logic [WORD_W-1:0] opnd  [N_OPND];
    logic [WORD_W-1:0] alu_res;
    logic [WORD_W-1:0] sh0, sh1, sh2;
    logic [WORD_W-1:0] nx0, nx1, nx2;

    assign raw[0] = opnd_top;
    assign raw[1] = opnd_second;
    assign raw[2] = opnd_third;

    stk_decode u_dec (.ins(in_instr), .dec(dec));

    // Byte mode: each operand lane keeps only its low byte
    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_mask
        assign opnd[gi] = dec.wide ? raw[gi] : (raw[gi] & LOW_MASK);
    end

    stk_arith #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_arith (
        .op(dec.op), .wide(dec.wide), .t_in(opnd[0]), .s_in(opnd[1]), .res(alu_res)
    );

    stk_permute #(.WORD_W(WORD_W)) u_perm (
        .op(dec.op), .t_in(opnd[0]), .s_in(opnd[1]), .u_in(opnd[2]),
        .slot0(sh0), .slot1(sh1), .slot2(sh2)
    );

    always_comb begin
        nx0 = '0;
        nx1 = '0;
        nx2 = '0;
        if (dec.known) begin
            if (dec.is_shuf) begin
                nx0 = sh0;
                nx1 = sh1;
                nx2 = sh2;
            end else begin
                nx0 = alu_res;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid       <= 1'b0;
            out_res0        <= '0;
            out_res1        <= '0;
            out_res2        <= '0;
            out_pop_cnt     <= '0;
            out_push_cnt    <= '0;
            out_wide        <= 1'b0;
            out_swap_stacks <= 1'b0;
            out_unsupported <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_res0        <= nx0;
                out_res1        <= nx1;
                out_res2        <= nx2;
                out_pop_cnt     <= dec.keep ? 2'd0 : dec.n_in;
                out_push_cnt    <= dec.n_out;
                out_wide        <= dec.wide & dec.known & ~dec.is_cmp;
                out_swap_stacks <= dec.ret;
                out_unsupported <= ~dec.known;
            end
        end
    end

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    assert_keep_no_pop_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_instr[7] |=> out_pop_cnt == 2'd0);
    assert_cmp_single_byte_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_instr[4:2] == 3'b010 |=>
        out_res0 <= WORD_W'(1) && !out_wide && out_push_cnt == 2'd1);
    assert_byte_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_instr[5] |=>
        out_res0[WORD_W-1:BYTE_W] == '0 && out_res1[WORD_W-1:BYTE_W] == '0 &&
        out_res2[WORD_W-1:BYTE_W] == '0 && !out_wide);
    assert_ret_copied_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_swap_stacks == $past(in_instr[6]));
    assert_unsupported_idle_R11: assert property (@(posedge clk) disable iff (rst)
        in_valid && (in_instr[4:0] == 5'h00 ||
                     (in_instr[4:0] > 5'h0B && in_instr[4:0] < 5'h18)) |=>
        out_unsupported && out_push_cnt == 2'd0 && out_pop_cnt == 2'd0);
endmodule

// File: tb/stk_exec_unit_bench.sv
`timescale 1ns/1ps
module stk_exec_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_instr = '0;
    logic [15:0] opnd_top = '0, opnd_second = '0, opnd_third = '0;
    logic        out_valid;
    logic [15:0] out_res0, out_res1, out_res2;
    logic [1:0]  out_pop_cnt, out_push_cnt;
    logic        out_wide, out_swap_stacks, out_unsupported;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stk_exec_unit u_stk_exec_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
        .opnd_top(opnd_top), .opnd_second(opnd_second), .opnd_third(opnd_third),
        .out_valid(out_valid), .out_res0(out_res0), .out_res1(out_res1),
        .out_res2(out_res2), .out_pop_cnt(out_pop_cnt), .out_push_cnt(out_push_cnt),
        .out_wide(out_wide), .out_swap_stacks(out_swap_stacks),
        .out_unsupported(out_unsupported)
    );

    typedef struct {
        logic [15:0] r0, r1, r2;
        logic [1:0]  pop, push;
        logic        wide, swap, unsup;
        string       req;
    } exp_t;

    function automatic exp_t model(input logic [7:0] ins, input logic [15:0] t,
                                   input logic [15:0] s, input logic [15:0] u);
        exp_t e;
        logic [15:0] m = ins[5] ? 16'hFFFF : 16'h00FF;
        t = t & m; s = s & m; u = u & m;
        e.r0 = 0; e.r1 = 0; e.r2 = 0; e.pop = 2; e.push = 1;
        e.wide = ins[5]; e.swap = ins[6]; e.unsup = 0; e.req = "R4";
        case (ins[4:0])
            5'h01: begin e.pop = 1; e.r0 = (t + 16'd1) & m; end
            5'h02: begin e.pop = 1; e.push = 0; e.req = "R3"; end
            5'h03: begin e.r0 = t; e.req = "R3"; end
            5'h04: begin e.push = 2; e.r0 = t; e.r1 = s; e.req = "R3"; end
            5'h05: begin e.pop = 3; e.push = 3; e.r0 = s; e.r1 = t; e.r2 = u; e.req = "R3"; end
            5'h06: begin e.pop = 1; e.push = 2; e.r0 = t; e.r1 = t; e.req = "R3"; end
            5'h07: begin e.push = 3; e.r0 = s; e.r1 = t; e.r2 = s; e.req = "R3"; end
            5'h08: begin e.r0 = {15'd0, s == t}; e.wide = 0; e.req = "R8"; end
            5'h09: begin e.r0 = {15'd0, s != t}; e.wide = 0; e.req = "R8"; end
            5'h0A: begin e.r0 = {15'd0, s > t};  e.wide = 0; e.req = "R8"; end
            5'h0B: begin e.r0 = {15'd0, s < t};  e.wide = 0; e.req = "R8"; end
            5'h18: e.r0 = (s + t) & m;
            5'h19: e.r0 = (s - t) & m;
            5'h1A: e.r0 = (s * t) & m;
            5'h1B: begin e.r0 = (t == 0) ? 16'd0 : s / t; e.req = "R5"; end
            5'h1C: begin e.r0 = s & t; e.req = "R6"; end
            5'h1D: begin e.r0 = s | t; e.req = "R6"; end
            5'h1E: begin e.r0 = s ^ t; e.req = "R6"; end
            5'h1F: begin e.r0 = ((s >> t[3:0]) << t[7:4]) & m; e.req = "R7"; end
            default: begin
                e.pop = 0; e.push = 0; e.wide = 0; e.unsup = 1; e.req = "R11";
            end
        endcase
        if (ins[7]) e.pop = 0;
        if (!ins[5]) e.req = {e.req, "/R9"};
        return e;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge, sample at the next falling edge (one rising edge between)
    task automatic run(input logic [7:0] ins, input logic [15:0] t,
                       input logic [15:0] s, input logic [15:0] u);
        exp_t e = model(ins, t, s, u);
        in_valid = 1'b1; in_instr = ins;
        opnd_top = t; opnd_second = s; opnd_third = u;
        @(negedge clk);
        chk("R1", "valid", 32'(out_valid), 32'd1);
        chk(e.req, "slot0", 32'(out_res0), 32'(e.r0));
        chk(e.req, "slot1", 32'(out_res1), 32'(e.r1));
        chk(e.req, "slot2", 32'(out_res2), 32'(e.r2));
        chk("R2", "pop", 32'(out_pop_cnt), 32'(e.pop));
        chk("R2", "push", 32'(out_push_cnt), 32'(e.push));
        chk("R9", "wide", 32'(out_wide), 32'(e.wide));
        chk("R10", "swap", 32'(out_swap_stacks), 32'(e.swap));
        chk("R11", "unsupported", 32'(out_unsupported), 32'(e.unsup));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset valid", 32'(out_valid), 32'd0);
        chk("R1", "reset slot0", 32'(out_res0), 32'd0);
        chk("R1", "reset counts", 32'({out_pop_cnt, out_push_cnt}), 32'd0);
        rst = 1'b0;

        // Directed corner cases
        run(8'h18, 16'h1201, 16'h34FF, 16'h0);     // R4 R9 byte add wraps, upper ignored
        run(8'h38, 16'h0001, 16'hFFFF, 16'h0);     // R4 short add wraps
        run(8'h39, 16'h0002, 16'h0001, 16'h0);     // R4 short sub wraps to FFFF
        run(8'h3A, 16'h0100, 16'h0100, 16'h0);     // R4 short mul wraps to 0
        run(8'h1B, 16'h0000, 16'h0055, 16'h0);     // R5 divide by zero
        run(8'h3B, 16'h0003, 16'h1000, 16'h0);     // R5 short divide
        run(8'h1F, 16'h0021, 16'h000F, 16'h0);     // R7 right 1 left 2
        run(8'h3F, 16'h0034, 16'h0FF0, 16'h0);     // R7 short shift
        run(8'h1E, 16'h00F0, 16'h003C, 16'h0);     // R6 xor
        run(8'h2A, 16'h00FF, 16'h0100, 16'h0);     // R8 short compare, byte result
        run(8'h0B, 16'h0042, 16'h0042, 16'h0);     // R8 less-than on equal
        run(8'h05, 16'h0011, 16'h0022, 16'h0033);  // R3 rotate
        run(8'h85, 16'h0011, 16'h0022, 16'h0033);  // R2 keep rotate
        run(8'h45, 16'h0011, 16'h0022, 16'h0033);  // R10 return flag
        run(8'h07, 16'h00AA, 16'h00BB, 16'h0);     // R3 over
        run(8'h26, 16'hBEEF, 16'h0, 16'h0);        // R3 short dup
        run(8'h03, 16'h0001, 16'h0002, 16'h0);     // R3 nip
        run(8'h04, 16'h0001, 16'h0002, 16'h0);     // R3 swap
        run(8'h02, 16'h0001, 16'h0002, 16'h0);     // R3 pop
        run(8'h01, 16'h00FF, 16'h0, 16'h0);        // R4 byte inc wraps
        run(8'h0C, 16'h1234, 16'h5678, 16'h9ABC);  // R11 unsupported
        run(8'h00, 16'h1234, 16'h5678, 16'h9ABC);  // R11 unsupported

        // R1: idle cycle drops out_valid
        in_valid = 1'b0;
        @(negedge clk);
        chk("R1", "idle valid", 32'(out_valid), 32'd0);

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [7:0] ins = 8'($urandom);
            if (($urandom % 4) != 0 && ins[4:0] > 5'h0B && ins[4:0] < 5'h18)
                ins[4:3] = 2'b11;
            run(ins, 16'($urandom), 16'($urandom), 16'($urandom));
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule